// File: doc/BRIEF.md
# Quad Tile Dispatch Arbiter

This block sits between a rasterizer and a bank of quad-wide shading pipelines. The rasterizer sends a stream of 2x2 pixel tiles (quads), one triangle after another. Each quad carries a triangle tag, tile coordinates, a four-lane coverage mask and a flag on the final quad of its triangle. The arbiter gives each covered quad, whole, to exactly one free pipeline. It picks that pipeline by a fixed lowest-index-first search. It then holds the pipeline busy until the pipeline reports that it has finished.

A static fuse vector removes defective pipelines from use, so the same block also serves reduced builds, such as three of four pipelines. Quads stay in stream order, so a triangle's quads are all issued before any quad of the next triangle. A running count of quads issued for the current triangle is exposed. A one-cycle completion pulse reports each finished triangle, together with its issued-quad total.

Top module: `quad_dispatch`

## Requirements
- R1: After reset no pipeline is busy, `pipe_valid` is all zero, `tri_done` is 0 and `tri_quad_count` is 0.
- R2: A quad with a nonzero coverage mask is offered to exactly one pipeline. The tag, coordinates and full coverage mask go out unchanged on the shared pipeline bus. A partly covered quad (for example coverage 4'b0001) still takes a whole pipeline.
- R3: The pipeline offered is the lowest-index one that is enabled and free. A pipeline counts as free when it is not busy, or when its `pipe_done` is high in the same cycle.
- R4: A pipeline whose bit in `cfg_pipe_en` is 0 is never offered a quad.
- R5: A pipeline becomes busy on the cycle its `pipe_valid` and `pipe_ready` are both high. It stays busy, and is offered nothing, until its `pipe_done` pulse.
- R6: A `pipe_done` pulse on a busy pipeline and a new issue to that pipeline in the same cycle leave it busy (free-then-busy).
- R7: A quad with coverage 4'b0000 is accepted (`in_ready` high) whenever some enabled pipeline is free. It raises no `pipe_valid` and occupies no pipeline.
- R8: `in_ready` is low whenever no enabled pipeline is free. With `cfg_pipe_en` all zero, no quad is ever accepted.
- R9: `tri_quad_count` counts the quads issued to pipelines since the last accepted end-of-triangle quad. Dropped quads are not counted, and the count returns to 0 after an end-of-triangle quad is accepted.
- R10: Accepting a quad with `in_last` high raises `tri_done` for exactly the following cycle. In that cycle `tri_done_count` holds the number of quads issued for that triangle, the last quad included if it was issued.
- R11: A `pipe_done` pulse on a pipeline that is not busy has no effect.
- R12: While the selected pipeline holds `pipe_ready` low, the quad waits on that pipeline and no other pipeline is offered the quad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pipe_en | input | NUM_PIPES | Static pipeline enable (0 = fused off) |
| in_valid | input | 1 | Upstream quad valid |
| in_ready | output | 1 | Upstream quad accepted |
| in_tri_id | input | TRI_W | Triangle tag |
| in_tile_x | input | COORD_W | Tile column |
| in_tile_y | input | COORD_W | Tile row |
| in_cover | input | 4 | Pixel coverage mask |
| in_last | input | 1 | Final quad of its triangle |
| pipe_valid | output | NUM_PIPES | Per-pipeline offer, one-hot or zero |
| pipe_ready | input | NUM_PIPES | Per-pipeline ready |
| pipe_done | input | NUM_PIPES | Per-pipeline completion pulse |
| pipe_tri_id | output | TRI_W | Shared bus: triangle tag |
| pipe_tile_x | output | COORD_W | Shared bus: tile column |
| pipe_tile_y | output | COORD_W | Shared bus: tile row |
| pipe_cover | output | 4 | Shared bus: coverage mask |
| tri_quad_count | output | CNT_W | Quads issued for the current triangle |
| tri_done | output | 1 | Triangle-complete pulse |
| tri_done_count | output | CNT_W | Issued-quad total of the finished triangle |

## Verification
The hardest situation to reach is a `pipe_done` arriving on a busy pipeline in the same cycle that a quad is waiting. The arbiter must then pick that very pipeline ahead of higher-index free ones, and the pipeline must stay busy. Reaching this takes a full set of busy pipelines together with sparse completion pulses. The stimulus sweeps all sixteen fuse patterns. Under each pattern it drives a long seeded sequence in which completions are rare, so the pipelines fill up. Coverage values, ready stalls, stray completions on idle pipelines and end-of-triangle flags are mixed in throughout, and every cycle is compared against an occupancy model kept in the bench.

// File: rtl/quad_dispatch_pkg.sv
`timescale 1ns/1ps
package quad_dispatch_pkg;
   localparam int QUAD_LANES = 4;
   typedef logic [QUAD_LANES-1:0] cover_t;
endpackage

// File: rtl/quad_pick.sv
`timescale 1ns/1ps
// Fixed-priority search: lowest index among the candidates wins.
module quad_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] cand,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = cand[i] & ~seen[i];
      assign seen[i+1] = seen[i] | cand[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/quad_busy_track.sv
`timescale 1ns/1ps
// Per-pipeline occupancy; done clears, issue sets, issue wins on overlap.
module quad_busy_track #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] issue,
   input  logic [N-1:0] done,
   output logic [N-1:0] busy
);
   for (genvar i = 0; i < N; i++) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        busy[i] <= 1'b0;
         else if (issue[i]) busy[i] <= 1'b1;
         else if (done[i])  busy[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/quad_tri_count.sv
`timescale 1ns/1ps
// Per-triangle issued-quad counter and completion pulse.
module quad_tri_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_fire,
   input  logic             last_fire,
   output logic [CNT_W-1:0] count,
   output logic             done_pulse,
   output logic [CNT_W-1:0] done_count
);
   logic [CNT_W-1:0] count_inc;
   assign count_inc = count + CNT_W'(issue_fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count      <= '0;
         done_pulse <= 1'b0;
         done_count <= '0;
      end else begin
         done_pulse <= last_fire;
         if (last_fire) begin
            done_count <= count_inc;
            count      <= '0;
         end else begin
            count      <= count_inc;
         end
      end
   end
endmodule

// File: rtl/quad_dispatch.sv
`timescale 1ns/1ps
module quad_dispatch
   import quad_dispatch_pkg::*;
#(
   parameter int NUM_PIPES = 4,
   parameter int TRI_W     = 8,
   parameter int COORD_W   = 10,
   parameter int CNT_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PIPES-1:0] cfg_pipe_en,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [TRI_W-1:0]     in_tri_id,
   input  logic [COORD_W-1:0]   in_tile_x,
   input  logic [COORD_W-1:0]   in_tile_y,
   input  logic [3:0]           in_cover,
   input  logic                 in_last,
   output logic [NUM_PIPES-1:0] pipe_valid,
   input  logic [NUM_PIPES-1:0] pipe_ready,
   input  logic [NUM_PIPES-1:0] pipe_done,
   output logic [TRI_W-1:0]     pipe_tri_id,
   output logic [COORD_W-1:0]   pipe_tile_x,
   output logic [COORD_W-1:0]   pipe_tile_y,
   output logic [3:0]           pipe_cover,
   output logic [CNT_W-1:0]     tri_quad_count,
   output logic                 tri_done,
   output logic [CNT_W-1:0]     tri_done_count
);
   if (NUM_PIPES < 1) begin : g_bad_pipes
      $error("quad_dispatch: NUM_PIPES must be at least 1");
   end
   if (QUAD_LANES != 4) begin : g_bad_lanes
      $error("quad_dispatch: quads are 2x2, four lanes");
   end
   if (CNT_W < 1 || TRI_W < 1 || COORD_W < 1) begin : g_bad_width
      $error("quad_dispatch: widths must be positive");
   end

   logic [NUM_PIPES-1:0] busy;
   logic [NUM_PIPES-1:0] free_vec;
   logic [NUM_PIPES-1:0] grant;
   logic [NUM_PIPES-1:0] issue;
   logic                 any_free;
   logic                 covered;
   logic                 sel_ready;
   logic                 accept;
   cover_t               cov;

   assign cov      = in_cover;
   assign covered  = |cov;
   assign free_vec = cfg_pipe_en & (~busy | pipe_done);

   quad_pick #(.N(NUM_PIPES)) u_pick (
      .cand  (free_vec),
      .grant (grant),
      .any   (any_free)
   );

   assign sel_ready  = |(grant & pipe_ready);
   assign in_ready   = any_free & (~covered | sel_ready);
   assign pipe_valid = (in_valid && covered) ? grant : '0;
   assign issue      = pipe_valid & pipe_ready;
   assign accept     = in_valid & in_ready;

   assign pipe_tri_id = in_tri_id;
   assign pipe_tile_x = in_tile_x;
   assign pipe_tile_y = in_tile_y;
   assign pipe_cover  = cov;

   quad_busy_track #(.N(NUM_PIPES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (issue),
      .done  (pipe_done),
      .busy  (busy)
   );

   quad_tri_count #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_fire (|issue),
      .last_fire  (accept & in_last),
      .count      (tri_quad_count),
      .done_pulse (tri_done),
      .done_count (tri_done_count)
   );
endmodule

// File: rtl/quad_dispatch_chk.sv
`timescale 1ns/1ps
module quad_dispatch_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] cfg_pipe_en,
   input logic         in_valid,
   input logic         in_ready,
   input logic [3:0]   in_cover,
   input logic         in_last,
   input logic [N-1:0] pipe_valid,
   input logic [N-1:0] pipe_ready,
   input logic [N-1:0] pipe_done,
   input logic         tri_done
);
   // Occupancy seen from the ports only.
   logic [N-1:0] sh_busy;
   logic [N-1:0] sh_free;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_busy <= '0;
      else        sh_busy <= (sh_busy & ~pipe_done) | (pipe_valid & pipe_ready);
   end
   assign sh_free = cfg_pipe_en & (~sh_busy | pipe_done);

   p_one_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pipe_valid));
   p_lowest_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_valid != '0) |-> (((pipe_valid - 1'b1) & sh_free) == '0));
   p_no_fused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pipe_valid & ~cfg_pipe_en) == '0));
   p_no_busy_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pipe_valid & sh_busy & ~pipe_done) == '0));
   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cover == 4'b0000) |-> (pipe_valid == '0));
   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_free == '0) |-> !in_ready);
   p_tri_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> tri_done);
   p_tri_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready && in_last) |=> !tri_done);
endmodule

bind quad_dispatch quad_dispatch_chk #(.N(NUM_PIPES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_pipe_en (cfg_pipe_en),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_cover    (in_cover),
   .in_last     (in_last),
   .pipe_valid  (pipe_valid),
   .pipe_ready  (pipe_ready),
   .pipe_done   (pipe_done),
   .tri_done    (tri_done)
);

// File: tb/quad_dispatch_bench.sv
`timescale 1ns/1ps
module quad_dispatch_bench;
   localparam int NP = 4;
   localparam int TW = 8;
   localparam int CW = 10;
   localparam int KW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] cfg_pipe_en = '1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [TW-1:0] in_tri_id = '0;
   logic [CW-1:0] in_tile_x = '0;
   logic [CW-1:0] in_tile_y = '0;
   logic [3:0]    in_cover = '0;
   logic          in_last = 1'b0;
   logic [NP-1:0] pipe_valid;
   logic [NP-1:0] pipe_ready = '0;
   logic [NP-1:0] pipe_done = '0;
   logic [TW-1:0] pipe_tri_id;
   logic [CW-1:0] pipe_tile_x;
   logic [CW-1:0] pipe_tile_y;
   logic [3:0]    pipe_cover;
   logic [KW-1:0] tri_quad_count;
   logic          tri_done;
   logic [KW-1:0] tri_done_count;

   always #2 clk = ~clk;

   quad_dispatch u_quad_dispatch (.*);

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] rng = 32'h1F2E3D4C;

   // bench model
   logic [NP-1:0] m_busy;
   logic [KW-1:0] m_count;
   logic          m_td;
   logic [KW-1:0] m_td_cnt;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic do_reset(input logic [NP-1:0] en);
      rst_n = 1'b0;
      cfg_pipe_en = en;
      in_valid = 1'b0;
      pipe_done = '0;
      pipe_ready = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_busy = '0; m_count = '0; m_td = 1'b0; m_td_cnt = '0;
      #1;
      chk("R1 pipe_valid after reset", 32'(pipe_valid), 32'h0);
      chk("R1 tri_done after reset", 32'(tri_done), 32'h0);
      chk("R1 tri_quad_count after reset", 32'(tri_quad_count), 32'h0);
   endtask

   task automatic step(input logic [NP-1:0] en, input logic [TW-1:0] tri_id);
      logic [NP-1:0] free_v, sel, exp_valid;
      logic          any, exp_ready, accept, disp;
      string         tg;
      @(negedge clk);
      chk("R10 tri_done pulse", 32'(tri_done), 32'(m_td));
      if (m_td) chk("R10 tri_done_count", 32'(tri_done_count), 32'(m_td_cnt));
      chk("R9 tri_quad_count", 32'(tri_quad_count), 32'(m_count));
      rng = nxt(rng);
      in_valid   = (rng[1:0] != 2'b00);
      in_cover   = (rng[7:6] == 2'b00) ? 4'b0000 : rng[5:2];
      in_last    = (rng[10:8] == 3'b000);
      in_tri_id  = tri_id;
      in_tile_x  = CW'(rng[23:14]);
      in_tile_y  = CW'(rng[31:22]);
      for (int i = 0; i < NP; i++) begin
         pipe_done[i]  = rng[11+i] & rng[15+i] & rng[19+i];
         pipe_ready[i] = ~(rng[24+i] & rng[28+i]);
      end
      #1;
      free_v = en & (~m_busy | pipe_done);
      sel = '0; any = 1'b0;
      for (int i = 0; i < NP; i++)
         if (free_v[i] && !any) begin sel[i] = 1'b1; any = 1'b1; end
      exp_valid = (in_valid && in_cover != 0) ? sel : '0;
      exp_ready = any && (in_cover == 0 || (sel & pipe_ready) != 0);
      if (in_valid && in_cover == 0)          tg = "R7 zero coverage";
      else if (en != '1)                      tg = "R4 R3 fused pick";
      else if ((m_busy & pipe_done) != 0)     tg = "R6 R3 done same cycle";
      else if (m_busy != 0)                   tg = "R5 R3 busy skip";
      else                                    tg = "R2 R3 pick";
      chk({tg, " pipe_valid"}, 32'(pipe_valid), 32'(exp_valid));
      if (!any)                               tg = "R8 no free pipe";
      else if ((sel & pipe_ready) == 0)       tg = "R12 hold on stalled pipe";
      else if ((~m_busy & pipe_done) != 0)    tg = "R11 idle done";
      else                                    tg = "R8 R7 ready";
      chk({tg, " in_ready"}, 32'(in_ready), 32'(exp_ready));
      if (exp_valid != 0) begin
         chk("R2 cover bus", 32'(pipe_cover), 32'(in_cover));
         chk("R2 tile bus", {pipe_tri_id, pipe_tile_x[9:0], pipe_tile_y[9:0]},
             {in_tri_id, in_tile_x[9:0], in_tile_y[9:0]});
      end
      accept = in_valid && exp_ready;
      disp   = accept && in_cover != 0;
      m_busy = (m_busy & ~pipe_done) | (disp ? sel : '0);
      m_td   = accept && in_last;
      if (m_td) begin
         m_td_cnt = m_count + KW'(disp);
         m_count  = '0;
      end else begin
         m_count  = m_count + KW'(disp);
      end
   endtask

   initial begin : main
      logic [TW-1:0] tid;
      tid = '0;
      for (int m = 0; m < 16; m++) begin
         do_reset(NP'(m));
         for (int s = 0; s < 80; s++) begin
            step(NP'(m), tid);
            if (in_valid && in_ready && in_last) tid = tid + 1'b1;
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : watchdog
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule